// File: doc/BRIEF.md
# Oscillator start-up hold timer

This block holds the processor core stalled until a crystal or ceramic resonator oscillator has proven that it runs. It counts rising edges of the raw oscillator input in that oscillator's own clock domain. The core is released only after a fixed number of edges has been seen. Counting is gated: after a power-on reset it waits for the power-up delay to clear, unless that delay is switched off. Entering sleep, waking, or changing the clock-mode select restarts the proof.

For an externally driven logic clock, and for RC and the remaining mode codes, the count is skipped. The stable flag is raised on the first open edge. The stable flag lives in the oscillator domain. It reaches the core's clock domain through a two-flop synchronizer, whose output is the run enable that gates program-counter advance.

Top module: `osc_start_hold`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, `osc_stable` is 0 after every `osc_clk` edge and `run_en` is 0 after every `sys_clk` edge, whatever the other inputs do.
- R2: With `clk_mode` 0, 1 or 2 (the crystal/resonator modes), `osc_stable` rises on exactly the 1024th counted `osc_clk` edge. Counted edges are those that sample the gate open. It is 0 after the 1023rd.
- R3: With `pwrt_enable` = 1, no edge is counted before the first `osc_clk` edge that samples `pwrt_done` = 1. That edge is counted as the first. Afterwards the gate stays open even if `pwrt_done` falls.
- R4: With `pwrt_enable` = 0, the gate is open from reset, and the first `osc_clk` edge after `rst` is released is counted as the first.
- R5: With `clk_mode` 3 (external logic clock) or 4 to 7 (RC and other bypass codes), `osc_stable` rises on the first edge that samples the gate open, with no edge count.
- R6: `run_en` is `osc_stable` passed through two `sys_clk` flops, so it rises and falls two `sys_clk` edges after `osc_stable` does.
- R7: An `osc_clk` edge that samples a `clk_mode` different from the previous edge's clears the count and `osc_stable`. A crystal mode then counts 1024 fresh edges after that edge. A bypass mode sets `osc_stable` on that same edge when the gate is open.
- R8: An `osc_clk` edge that samples `sleep_enter` = 1 clears `osc_stable`, and it stays 0 until a wake.
- R9: An edge that samples `wake` = 1 while asleep restarts the proof. In a crystal mode, `osc_stable` rises on the 1024th edge after that edge. In a bypass mode it rises on that edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Raw oscillator input; clocks the edge counter and control |
| sys_clk | input | 1 | Core clock domain for the run enable |
| rst | input | 1 | Power-on reset, synchronous, active high, held in both domains |
| pwrt_enable | input | 1 | 1 when the power-up delay must clear before counting |
| pwrt_done | input | 1 | Power-up delay has expired |
| sleep_enter | input | 1 | Pulse: core is entering sleep |
| wake | input | 1 | Pulse: wake-up from sleep |
| clk_mode | input | 3 | 0..2 crystal/resonator, 3 external clock, 4..7 RC and other bypass |
| run_en | output | 1 | Core may advance the program counter |
| osc_stable | output | 1 | Oscillator proven stable (oscillator domain) |

## Verification
Counted from the first edge that samples the gate open, `osc_stable` is due on that edge in bypass modes and on the 1024th edge in crystal modes. `run_en` is due two core-clock edges later. The bench drives every input just after a falling edge and samples the outputs at the next falling edge. It counts rising edges itself, checking `osc_stable` low after edge N-1 and high after edge N, and `run_en` low after N+1 and high after N+2. After a mode change, sleep or wake, the same window is counted from the edge that sampled that event.

// File: rtl/osc_hold_pkg.sv
package osc_hold_pkg;

    typedef enum logic [2:0] {
        MODE_XTAL_LOW  = 3'd0,
        MODE_XTAL_STD  = 3'd1,
        MODE_XTAL_FAST = 3'd2,
        MODE_EXT_LOGIC = 3'd3,
        MODE_RC        = 3'd4,
        MODE_BYP_5     = 3'd5,
        MODE_BYP_6     = 3'd6,
        MODE_BYP_7     = 3'd7
    } clk_mode_e;

    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,
        ST_STABLE = 2'd1,
        ST_ASLEEP = 2'd2
    } hold_state_e;

    typedef struct packed {
        logic clear;
        logic step;
    } cnt_cmd_t;

    function automatic logic needs_count(input logic [2:0] mode);
        return mode <= MODE_XTAL_FAST;
    endfunction

endpackage

// File: rtl/osc_hold_counter.sv
module osc_hold_counter
    import osc_hold_pkg::*;
#(
    parameter int TARGET = 1024,
    parameter int CNT_W  = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_cmd_t         cmd,
    output logic [CNT_W-1:0] count,
    output logic             done
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(TARGET - 1);

    assign done = cmd.step && !cmd.clear && (count == LAST);

    always_ff @(posedge clk) begin
        if (rst || cmd.clear || done) begin
            count <= '0;
        end else if (cmd.step) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/osc_hold_ctrl.sv
module osc_hold_ctrl
    import osc_hold_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pwrt_enable,
    input  logic       pwrt_done,
    input  logic       sleep_enter,
    input  logic       wake,
    input  logic [2:0] clk_mode,
    input  logic       count_done,
    output cnt_cmd_t   cmd,
    output logic       stable,
    output logic       pwrt_seen
);

    hold_state_e state_q, state_d;
    logic        stable_d;
    logic        seen_d;
    logic [2:0]  mode_q;
    logic        gate;
    logic        mode_moved;

    assign gate       = pwrt_seen || pwrt_done || !pwrt_enable;
    assign mode_moved = clk_mode != mode_q;

    always_comb begin
        state_d   = state_q;
        stable_d  = stable;
        seen_d    = pwrt_seen || (pwrt_enable && pwrt_done);
        cmd       = '0;
        if (sleep_enter) begin
            state_d   = ST_ASLEEP;
            stable_d  = 1'b0;
            cmd.clear = 1'b1;
        end else if (state_q == ST_ASLEEP) begin
            if (wake) begin
                cmd.clear = 1'b1;
                if (!needs_count(clk_mode) && gate) begin
                    state_d  = ST_STABLE;
                    stable_d = 1'b1;
                end else begin
                    state_d  = ST_ARMED;
                end
            end
        end else if (mode_moved) begin
            cmd.clear = 1'b1;
            state_d   = ST_ARMED;
            stable_d  = 1'b0;
            if (!needs_count(clk_mode) && gate) begin
                state_d  = ST_STABLE;
                stable_d = 1'b1;
            end
        end else if (state_q == ST_ARMED && gate) begin
            if (!needs_count(clk_mode)) begin
                state_d  = ST_STABLE;
                stable_d = 1'b1;
            end else begin
                cmd.step = 1'b1;
                if (count_done) begin
                    state_d  = ST_STABLE;
                    stable_d = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_ARMED;
            stable    <= 1'b0;
            pwrt_seen <= 1'b0;
            mode_q    <= clk_mode;
        end else begin
            state_q   <= state_d;
            stable    <= stable_d;
            pwrt_seen <= seen_d;
            mode_q    <= clk_mode;
        end
    end

endmodule

// File: rtl/osc_hold_sync.sv
module osc_hold_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/osc_start_hold.sv
module osc_start_hold
    import osc_hold_pkg::*;
#(
    parameter int TARGET      = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       osc_clk,
    input  logic       sys_clk,
    input  logic       rst,
    input  logic       pwrt_enable,
    input  logic       pwrt_done,
    input  logic       sleep_enter,
    input  logic       wake,
    input  logic [2:0] clk_mode,
    output logic       run_en,
    output logic       osc_stable
);

    localparam int CNT_W = $clog2(TARGET + 1);

    cnt_cmd_t         cmd_w;
    logic [CNT_W-1:0] count_w;
    logic             done_w;
    logic             pwrt_seen_w;

    osc_hold_counter #(
        .TARGET (TARGET),
        .CNT_W  (CNT_W)
    ) i_counter (
        .clk   (osc_clk),
        .rst   (rst),
        .cmd   (cmd_w),
        .count (count_w),
        .done  (done_w)
    );

    osc_hold_ctrl i_ctrl (
        .clk         (osc_clk),
        .rst         (rst),
        .pwrt_enable (pwrt_enable),
        .pwrt_done   (pwrt_done),
        .sleep_enter (sleep_enter),
        .wake        (wake),
        .clk_mode    (clk_mode),
        .count_done  (done_w),
        .cmd         (cmd_w),
        .stable      (osc_stable),
        .pwrt_seen   (pwrt_seen_w)
    );

    osc_hold_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk (sys_clk),
        .rst (rst),
        .d   (osc_stable),
        .q   (run_en)
    );

endmodule

// File: rtl/osc_start_hold_chk.sv
module osc_start_hold_chk
    import osc_hold_pkg::*;
#(
    parameter int TARGET = 1024,
    parameter int CNT_W  = 11
) (
    input logic             osc_clk,
    input logic             sys_clk,
    input logic             rst,
    input logic             pwrt_enable,
    input logic             pwrt_done,
    input logic             sleep_enter,
    input logic [2:0]       clk_mode,
    input logic             run_en,
    input logic             osc_stable,
    input logic [CNT_W-1:0] cnt,
    input logic             pwrt_seen
);

    logic osc_rst_q = 1'b0;
    logic sys_rst_q = 1'b0;

    always_ff @(posedge osc_clk) begin
        if (osc_rst_q) begin
            a_r1_stable_low: assert (!osc_stable);
        end
        osc_rst_q <= rst;
    end

    always_ff @(posedge sys_clk) begin
        if (sys_rst_q) begin
            a_r1_run_low: assert (!run_en);
        end
        sys_rst_q <= rst;
    end

    a_r2_full_count: assert property (@(posedge osc_clk) disable iff (rst)
        ($rose(osc_stable) && needs_count(clk_mode)) |-> ($past(cnt) == CNT_W'(TARGET - 1)));

    a_r2_count_bound: assert property (@(posedge osc_clk) disable iff (rst)
        cnt < CNT_W'(TARGET));

    a_r3_gate_closed: assert property (@(posedge osc_clk) disable iff (rst)
        (!pwrt_seen && pwrt_enable && !pwrt_done) |=> $stable(cnt));

    a_r7_mode_restart: assert property (@(posedge osc_clk) disable iff (rst)
        ((clk_mode != $past(clk_mode)) && needs_count(clk_mode) && !sleep_enter)
        |=> (!osc_stable && cnt == '0));

    a_r8_sleep_clears: assert property (@(posedge osc_clk) disable iff (rst)
        sleep_enter |=> !osc_stable);

endmodule

bind osc_start_hold osc_start_hold_chk #(
    .TARGET (TARGET),
    .CNT_W  (CNT_W)
) i_chk (
    .osc_clk     (osc_clk),
    .sys_clk     (sys_clk),
    .rst         (rst),
    .pwrt_enable (pwrt_enable),
    .pwrt_done   (pwrt_done),
    .sleep_enter (sleep_enter),
    .clk_mode    (clk_mode),
    .run_en      (run_en),
    .osc_stable  (osc_stable),
    .cnt         (count_w),
    .pwrt_seen   (pwrt_seen_w)
);

// File: tb/test_osc_start_hold.sv
module test_osc_start_hold;

    logic       osc_clk = 1'b0;
    logic       sys_clk;
    logic       rst = 1'b1;
    logic       pwrt_enable = 1'b0;
    logic       pwrt_done = 1'b0;
    logic       sleep_enter = 1'b0;
    logic       wake = 1'b0;
    logic [2:0] clk_mode = 3'd0;
    logic       run_en;
    logic       osc_stable;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 osc_clk = ~osc_clk;
    assign sys_clk = osc_clk;

    osc_start_hold i_osc_start_hold (
        .osc_clk     (osc_clk),
        .sys_clk     (sys_clk),
        .rst         (rst),
        .pwrt_enable (pwrt_enable),
        .pwrt_done   (pwrt_done),
        .sleep_enter (sleep_enter),
        .wake        (wake),
        .clk_mode    (clk_mode),
        .run_en      (run_en),
        .osc_stable  (osc_stable)
    );

    function automatic int edges_needed(input logic [2:0] m);
        return (m <= 3'd2) ? 1024 : 1;
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge osc_clk);
        @(negedge osc_clk);
    endtask

    task automatic do_reset(input int len);
        rst = 1'b1;
        sleep_enter = 1'b0;
        wake = 1'b0;
        repeat (len) tick();
        chk("R1", "osc_stable in reset", osc_stable, 1'b0);
        chk("R1", "run_en in reset", run_en, 1'b0);
        pwrt_done = 1'b0;
        rst = 1'b0;
    endtask

    // counts n rising edges from now; release due on edge n, run_en two edges later (R6)
    task automatic expect_release(input int n, input string req, input bit drop_gate);
        for (int k = 1; k <= n; k++) begin
            tick();
            if (drop_gate) pwrt_done = 1'b0;
            if (k == n - 1) chk(req, "osc_stable before last edge", osc_stable, 1'b0);
            if (k == n)     chk(req, "osc_stable on last edge", osc_stable, 1'b1);
        end
        tick();
        chk("R6", "run_en one edge after stable", run_en, 1'b0);
        tick();
        chk("R6", "run_en two edges after stable", run_en, 1'b1);
    endtask

    task automatic power_case(input logic [2:0] m, input bit pen, input int delay, input bit drop_gate);
        clk_mode = m;
        pwrt_enable = pen;
        do_reset(3);
        if (pen) begin
            repeat (delay) tick();
            chk("R3", "no release before power-up done", osc_stable, 1'b0);
            chk("R3", "core held before power-up done", run_en, 1'b0);
            pwrt_done = 1'b1;
            expect_release(edges_needed(m), (m <= 3'd2) ? "R2" : "R5", drop_gate);
        end else begin
            expect_release(edges_needed(m), (m <= 3'd2) ? "R4" : "R5", 1'b0);
        end
    endtask

    task automatic sleep_wake();
        sleep_enter = 1'b1;
        tick();
        sleep_enter = 1'b0;
        chk("R8", "stable cleared by sleep", osc_stable, 1'b0);
        chk("R6", "run_en lags sleep by two", run_en, 1'b1);
        tick();
        chk("R6", "run_en one edge after sleep", run_en, 1'b1);
        tick();
        chk("R6", "run_en falls two edges after sleep", run_en, 1'b0);
        repeat (5) tick();
        chk("R8", "stable held low while asleep", osc_stable, 1'b0);
        wake = 1'b1;
        tick();
        wake = 1'b0;
        if (clk_mode <= 3'd2) begin
            chk("R9", "crystal not stable on wake edge", osc_stable, 1'b0);
            expect_release(1024, "R9", 1'b0);
        end else begin
            chk("R9", "bypass stable on wake edge", osc_stable, 1'b1);
            tick();
            chk("R6", "run_en after wake +1", run_en, 1'b0);
            tick();
            chk("R6", "run_en after wake +2", run_en, 1'b1);
        end
    endtask

    initial begin
        void'($urandom(32'd715));

        // R1: long reset with power-up done high and bypass mode
        clk_mode = 3'd3;
        pwrt_enable = 1'b0;
        pwrt_done = 1'b1;
        do_reset(20);

        // directed power-up cases
        power_case(3'd0, 1'b1, 7, 1'b0);   // R2 low-power crystal
        power_case(3'd3, 1'b0, 0, 1'b0);   // R5 external clock, immediate
        power_case(3'd4, 1'b1, 3, 1'b0);   // R5 RC bypass
        power_case(3'd2, 1'b1, 4, 1'b1);   // R3 gate latched after one-cycle pulse
        power_case(3'd1, 1'b0, 0, 1'b0);   // R4 count from reset release
        sleep_wake();                      // R8 R9 crystal
        power_case(3'd3, 1'b0, 0, 1'b0);
        sleep_wake();                      // R8 R9 bypass

        // R7: mode change while counting, while stable, and to bypass
        clk_mode = 3'd1;
        pwrt_enable = 1'b0;
        do_reset(3);
        repeat (500) tick();
        clk_mode = 3'd2;
        tick();
        chk("R7", "restart clears stable", osc_stable, 1'b0);
        expect_release(1024, "R7", 1'b0);
        clk_mode = 3'd0;
        tick();
        chk("R7", "change while stable clears it", osc_stable, 1'b0);
        expect_release(1024, "R7", 1'b0);
        clk_mode = 3'd1;
        tick();
        repeat (300) tick();
        chk("R7", "recount in progress", osc_stable, 1'b0);
        clk_mode = 3'd3;
        tick();
        chk("R7", "switch to bypass releases on change edge", osc_stable, 1'b1);
        tick();
        chk("R6", "run_en +1 after bypass switch", run_en, 1'b0);
        tick();
        chk("R6", "run_en +2 after bypass switch", run_en, 1'b1);

        // constrained random cases
        for (int i = 0; i < 6; i++) begin
            logic [2:0] m;
            bit pen;
            int dly;
            bit drop;
            m = 3'($urandom % 8);
            pen = 1'($urandom % 2);
            dly = int'($urandom % 16);
            drop = 1'($urandom % 2);
            power_case(m, pen, dly, drop);
            sleep_wake();
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge osc_clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule